// File: doc/BRIEF.md
# Dual PWM Charge-Pump Driver

This block produces two pulse-width-modulated drive signals for external DC-to-DC charge pumps. Software sets the on-time of each drive, in sixteenths of a PWM period, through one 16-bit read/write control register. Drive 1 has a single ratio field. Drive 0 has two fields: one used while the system runs from its battery and one used while it runs from an external supply. Two supply-status inputs choose between them on the fly.

Each PWM period has 16 steps. Each step lasts a fixed number of master clocks, set by a mode parameter: 12 clocks for an 18.432 MHz master clock, or 8 clocks for a 13 MHz one. Either way, an 8/16 ratio gives a square wave near 100 kHz. Each drive samples two things while the chip is in reset. It takes its own pin level, which fixes the polarity of the drive. It also takes a feedback input, which can disable the drive. When a drive is disabled, its counters stop and it holds its inactive level. A new ratio, or a new choice of supply field, takes effect only when the current period ends.

Top module: `pumpDriver`

## Requirements
- R1: Reset clears all twelve ratio bits, so the register reads zero. Each drive output then sits at its inactive level.
- R2: The register layout is fixed. Bits 3:0 hold drive 0's battery ratio. Bits 7:4 hold drive 0's external-supply ratio. Bits 11:8 hold drive 1's ratio. A read returns the stored fields, and bits 15:12 always read zero whatever was written.
- R3: For a ratio N from 1 to 15, the drive is active for N*S consecutive master clocks in every period of 16*S clocks. S is 12 when MASTER_13M is 0, and 8 when MASTER_13M is 1.
- R4: When a drive's effective ratio is zero, its output stays at the inactive level. Its step counter is held at zero and its prescaler is stopped.
- R5: Drive 0 uses the external-supply field (bits 7:4) when nextPwr is 1 or battOk is 0. Otherwise it uses the battery field (bits 3:0).
- R6: A change of a drive's ratio takes effect only at the end of a PWM period, that is after step 15. A write that lands while the output is inactive inside a period cannot produce an extra pulse in that period.
- R7: drvSense[i] is sampled while rstN is low. A sampled 0 makes drive i active-high (inactive level 0). A sampled 1 makes it active-low (inactive level 1).
- R8: fbIn[i] is sampled while rstN is low. A sampled 1 disables drive i whatever its ratio field holds.
- R9: The step counter of a running drive only ever advances by one, wrapping from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset; polarity and feedback are sampled while it is low |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Register read value; bits 15:12 read zero |
| battOk | input | 1 | Battery-good status flag |
| nextPwr | input | 1 | Set when running from an external (non-battery) supply |
| fbIn | input | 2 | Feedback inputs, one per drive; a high level at reset disables that drive |
| drvSense | input | 2 | Level seen on each drive pin, sampled at reset for polarity |
| drvOut | output | 2 | PWM drive outputs |

## Verification
The hardest case to reach is a ratio write that lands partway through a period of a running drive. It has to arrive after the pulse has ended but before step 15. Only then does a design that applies the new value at once give itself away by pulsing again in the same period. The bench runs drive 0 at ratio 4 and waits for the falling edge of its output. It waits two more steps, then writes ratio 12. It then checks that the output stays inactive through the rest of that period, and that the next period carries the new on-time. Polarity and feedback are set only during reset, so the bench asserts reset again with different pin-sense and feedback levels to reach those cases.

// File: rtl/pumpDrvPkg.sv
package pumpDrvPkg;

  localparam int NUM_DRV  = 2;
  localparam int RATIO_W  = 4;
  localparam int STEP_W   = 4;
  localparam int REG_W    = 16;
  localparam int FIELD_W  = NUM_DRV * RATIO_W + RATIO_W;  // three ratio fields

  typedef logic [RATIO_W-1:0] ratio_t;

  // Strobes and levels from the control side to the datapath.
  typedef struct packed {
    logic [NUM_DRV-1:0]        chanEn;
    ratio_t [NUM_DRV-1:0]      reqRatio;
  } pumpCtrlBus_t;

  // Master clocks per PWM step for the selected clock mode.
  function automatic int stepClks(input bit master13m);
    return master13m ? 8 : 12;
  endfunction

endpackage

// File: rtl/pumpDrvCtrl.sv
module pumpDrvCtrl
  import pumpDrvPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic                  battOk,
  input  logic                  nextPwr,
  input  logic [NUM_DRV-1:0]    fbIn,
  output pumpCtrlBus_t          ctrlBus,
  output logic [NUM_DRV-1:0]    fbOff
);

  logic [FIELD_W-1:0] fieldReg;
  logic               useExt;
  ratio_t             battRatio;
  ratio_t             extRatio;
  ratio_t             drv1Ratio;

  // Ratio fields; unused top bits are not stored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        fieldReg <= '0;
    else if (regWrEn) fieldReg <= regWrData[FIELD_W-1:0];
  end

  // Feedback disable levels, captured while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) fbOff <= fbIn;
  end

  assign battRatio = fieldReg[RATIO_W-1:0];
  assign extRatio  = fieldReg[2*RATIO_W-1:RATIO_W];
  assign drv1Ratio = fieldReg[3*RATIO_W-1:2*RATIO_W];

  // External field whenever an outside supply is present or the battery is not good.
  assign useExt = nextPwr | ~battOk;

  always_comb begin
    ctrlBus.reqRatio[0] = useExt ? extRatio : battRatio;
    ctrlBus.reqRatio[1] = drv1Ratio;
    ctrlBus.chanEn      = ~fbOff;
  end

  assign regRdData = {{(REG_W-FIELD_W){1'b0}}, fieldReg};

endmodule

// File: rtl/pumpPwmChannel.sv
module pumpPwmChannel
  import pumpDrvPkg::*;
#(
  parameter int STEP_CLKS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  ratio_t            reqRatio,
  input  logic              polLow,
  output logic              pwmOut,
  output ratio_t            curRatio,
  output logic [STEP_W-1:0] stepCnt
);

  localparam int PRE_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_CLKS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = '1;

  logic [PRE_W-1:0] preCnt;
  ratio_t           nextRatio;
  logic             running;
  logic             preLast;
  logic             pulse;

  assign nextRatio = chanEn ? reqRatio : '0;
  // Counting is enabled only while a nonzero ratio is loaded: the gated clock.
  assign running   = (curRatio != '0);
  assign preLast   = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      stepCnt  <= '0;
      curRatio <= '0;
    end else if (!running) begin
      preCnt   <= '0;
      stepCnt  <= '0;
      curRatio <= nextRatio;
    end else if (preLast) begin
      preCnt  <= '0;
      stepCnt <= stepCnt + 1'b1;
      if (stepCnt == STEP_LAST) curRatio <= nextRatio;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign pulse = running && (stepCnt < STEP_W'(curRatio));

  // Registered pin driver so the pad sees no decode glitches.
  always_ff @(posedge clk) begin
    pwmOut <= pulse ^ polLow;
  end

endmodule

// File: rtl/pumpPwmDatapath.sv
module pumpPwmDatapath
  import pumpDrvPkg::*;
#(
  parameter int STEP_CLKS = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pumpCtrlBus_t                ctrlBus,
  input  logic [NUM_DRV-1:0]          drvSense,
  output logic [NUM_DRV-1:0]          drvOut,
  output ratio_t [NUM_DRV-1:0]        chanRatio,
  output logic [NUM_DRV-1:0][STEP_W-1:0] chanStep
);

  logic [NUM_DRV-1:0] polLow;

  // Pin level seen during reset decides each drive's sense.
  always_ff @(posedge clk) begin
    if (!rstN) polLow <= drvSense;
  end

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_chan
    pumpPwmChannel #(.STEP_CLKS(STEP_CLKS)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .chanEn   (ctrlBus.chanEn[g]),
      .reqRatio (ctrlBus.reqRatio[g]),
      .polLow   (polLow[g]),
      .pwmOut   (drvOut[g]),
      .curRatio (chanRatio[g]),
      .stepCnt  (chanStep[g])
    );
  end

endmodule

// File: rtl/pumpDriver.sv
module pumpDriver
  import pumpDrvPkg::*;
#(
  parameter bit MASTER_13M = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        battOk,
  input  logic        nextPwr,
  input  logic [1:0]  fbIn,
  input  logic [1:0]  drvSense,
  output logic [1:0]  drvOut
);

  localparam int STEP_CLKS = stepClks(MASTER_13M);

  pumpCtrlBus_t                      ctrlBus;
  logic [NUM_DRV-1:0]                fbOff;
  ratio_t [NUM_DRV-1:0]              chanRatio;
  logic [NUM_DRV-1:0][STEP_W-1:0]    chanStep;

  pumpDrvCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .battOk    (battOk),
    .nextPwr   (nextPwr),
    .fbIn      (fbIn),
    .ctrlBus   (ctrlBus),
    .fbOff     (fbOff)
  );

  pumpPwmDatapath #(.STEP_CLKS(STEP_CLKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlBus   (ctrlBus),
    .drvSense  (drvSense),
    .drvOut    (drvOut),
    .chanRatio (chanRatio),
    .chanStep  (chanStep)
  );

endmodule

// File: rtl/pumpDriverChk.sv
module pumpDriverChk
  import pumpDrvPkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic [15:0]                    regRdData,
  input logic [1:0]                     drvOut,
  input logic [NUM_DRV-1:0]             fbOff,
  input ratio_t [NUM_DRV-1:0]           chanRatio,
  input logic [NUM_DRV-1:0][STEP_W-1:0] chanStep
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (regRdData == 16'h0000));

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_chk
    // R9
    step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(chanStep[i]) |-> (chanStep[i] == $past(chanStep[i]) + 4'd1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanRatio[i] == '0) |-> (chanStep[i] == '0));

    // R4
    idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((chanRatio[i] == '0) && ($past(chanRatio[i]) == '0) && $past(rstN))
        |=> $stable(drvOut[i]));

    // R6
    ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((chanRatio[i] != $past(chanRatio[i])) && ($past(chanRatio[i]) != '0))
        |-> ($past(chanStep[i]) == 4'hF));

    // R8
    fb_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
      fbOff[i] |-> (chanRatio[i] == '0));
  end

endmodule

bind pumpDriver pumpDriverChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdData (regRdData),
  .drvOut    (drvOut),
  .fbOff     (fbOff),
  .chanRatio (chanRatio),
  .chanStep  (chanStep)
);

// File: tb/tb_pumpDriver.sv
module tb_pumpDriver;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] rdA, rdB;
  logic        battOk, nextPwr;
  logic [1:0]  fbIn, drvSense;
  logic [1:0]  outA, outB;
  logic [3:0]  allOut;

  int nVec  = 0;
  int nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  pumpDriver #(.MASTER_13M(1'b0)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rdA), .battOk(battOk), .nextPwr(nextPwr), .fbIn(fbIn),
    .drvSense(drvSense), .drvOut(outA)
  );

  pumpDriver #(.MASTER_13M(1'b1)) dut13 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rdB), .battOk(battOk), .nextPwr(nextPwr), .fbIn(fbIn),
    .drvSense(drvSense), .drvOut(outB)
  );

  assign allOut = {outB, outA};

  // Vector: register value, nextPwr, battOk
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {16'h000A, 1'b0, 1'b1}, {16'h012F, 1'b0, 1'b1},
    {16'h021E, 1'b1, 1'b1}, {16'h033D, 1'b0, 1'b0},
    {16'h0444, 1'b0, 1'b1}, {16'h055B, 1'b1, 1'b1},
    {16'h0666, 1'b0, 1'b1}, {16'h0779, 1'b1, 1'b1},
    {16'h0808, 1'b0, 1'b1}, {16'h0990, 1'b0, 1'b1},
    {16'h0A0B, 1'b0, 1'b1}, {16'h0B2B, 1'b1, 1'b1},
    {16'h0CC4, 1'b1, 1'b1}, {16'h0D9D, 1'b1, 1'b1},
    {16'h0EE2, 1'b1, 1'b1}, {16'h0F6D, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
  endtask

  task automatic doReset(input logic [1:0] sense, input logic [1:0] fb);
    @(negedge clk);
    rstN = 1'b0; drvSense = sense; fbIn = fb;
    regWrEn = 1'b0; regWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Measure on-time and period of output idx (active level act), in clocks.
  task automatic measure(input int idx, input logic act, output int onC, output int perC);
    int t;
    onC = -1; perC = -1;
    t = 0;
    while (allOut[idx] == act && t < 1000) begin @(negedge clk); t++; end
    t = 0;
    while (allOut[idx] != act && t < 1000) begin @(negedge clk); t++; end
    if (t >= 1000) return;
    onC = 0;
    while (allOut[idx] == act && onC < 1000) begin @(negedge clk); onC++; end
    perC = onC;
    while (allOut[idx] != act && perC < 2000) begin @(negedge clk); perC++; end
  endtask

  // Count active cycles of output idx over n clocks.
  task automatic countActive(input int idx, input logic act, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (allOut[idx] == act) cnt++;
    end
  endtask

  initial begin
    int onC, perC, cnt;
    logic [15:0] rv;
    logic [3:0]  r0, r1, er;
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0;
    battOk = 1'b1; nextPwr = 1'b0; fbIn = 2'b00; drvSense = 2'b00;

    // R1: reset state
    doReset(2'b00, 2'b00);
    @(negedge clk);
    chk("R1 reg after reset", int'(rdA), 0);
    chk("R1 outputs after reset", int'(allOut), 0);

    // R2: readback and unused bits
    wrReg(16'hF5A3);
    @(negedge clk);
    chk("R2 readback, top nibble zero", int'(rdA), 16'h05A3);
    wrReg(16'h0000);
    repeat (400) @(negedge clk);

    // Table walk: R3, R4, R5 in both clock modes
    for (int v = 0; v < NV; v++) begin
      rv = VEC[v][17:2];
      nextPwr = VEC[v][1];
      battOk  = VEC[v][0];
      wrReg(rv);
      r0 = (nextPwr || !battOk) ? rv[7:4] : rv[3:0];  // R5 selection
      r1 = rv[11:8];
      repeat (32 * 12 + 10) @(negedge clk);
      for (int w = 0; w < 4; w++) begin
        int s;
        s  = (w < 2) ? 12 : 8;
        er = (w % 2 == 0) ? r0 : r1;
        if (er == 0) begin
          countActive(w, 1'b1, 20 * s, cnt);
          chk($sformatf("R4 vec%0d out%0d idle", v, w), cnt, 0);
        end else begin
          measure(w, 1'b1, onC, perC);
          chk($sformatf("R3 R5 vec%0d out%0d on", v, w), onC, int'(er) * s);
          chk($sformatf("R3 vec%0d out%0d period", v, w), perC, 16 * s);
        end
      end
    end

    // R6: write during the low part of a running period
    nextPwr = 1'b0; battOk = 1'b1;
    wrReg(16'h0004);
    repeat (32 * 12 + 10) @(negedge clk);
    while (allOut[0] != 1'b1) @(negedge clk);
    while (allOut[0] == 1'b1) @(negedge clk);
    repeat (2 * 12) @(negedge clk);
    wrReg(16'h000C);
    countActive(0, 1'b1, 8 * 12, cnt);
    chk("R6 no pulse before boundary", cnt, 0);
    measure(0, 1'b1, onC, perC);
    chk("R6 new ratio after boundary", onC, 12 * 12);

    // R7: drive 1 active-low, drive 0 active-high
    doReset(2'b10, 2'b00);
    @(negedge clk);
    chk("R7 inactive levels after reset", int'(outA), 2);
    wrReg(16'h0303);
    repeat (32 * 12 + 10) @(negedge clk);
    measure(1, 1'b0, onC, perC);
    chk("R7 active-low on-time", onC, 3 * 12);
    chk("R7 active-low period", perC, 16 * 12);
    measure(0, 1'b1, onC, perC);
    chk("R7 active-high on-time", onC, 3 * 12);

    // R8: feedback disables drive 0 only
    doReset(2'b00, 2'b01);
    wrReg(16'h0505);
    repeat (32 * 12 + 10) @(negedge clk);
    countActive(0, 1'b1, 20 * 12, cnt);
    chk("R8 drive0 disabled by feedback", cnt, 0);
    measure(1, 1'b1, onC, perC);
    chk("R8 drive1 still runs", onC, 5 * 12);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule